// File: doc/BRIEF.md
# SPI Buffer Interrupt Event Logic

This block sits beside the transmit and receive FIFOs of a serial peripheral channel and turns their occupancy and activity into three interrupt flags: a transmit event, a receive event and an error event. It does not hold any data. It observes the FIFO fill counts, the read request from the shifter, the write request from the receive assembler, software reads, a shift-complete pulse and an external frame-error pulse.

Each direction has a 2-bit mode select. The select chooses which occupancy condition raises the flag. For transmit the choices are: some free room, at least half free, completely empty, or transmission fully finished. For receive the choices are: full, at least half full, not empty, or just drained by a read. The error flag combines three causes. Each cause is also kept in its own sticky bit: receive overflow, transmit underrun and frame error. On overflow or underrun the block gates the FIFO strobe, so the offending word is dropped and the FIFO contents are unchanged.

All flags are sticky. Software clears a flag by pulsing its write-one-to-clear input. An event that arrives in the same cycle as the clear wins, so the flag stays set.

Top module: `spi_irq_events`

## Requirements
- R1: With `tx_mode` = 2'b11, `tx_flag` is set on the clock after any cycle in which `tx_count` < DEPTH.
- R2: With `tx_mode` = 2'b10, `tx_flag` is set on the clock after any cycle in which the free slots (DEPTH − `tx_count`) are at least DEPTH/2.
- R3: With `tx_mode` = 2'b01, `tx_flag` is set on the clock after any cycle in which `tx_count` = 0.
- R4: With `tx_mode` = 2'b00, `tx_flag` is set on the clock after a cycle in which `shift_done` is high and `tx_count` = 0. No occupancy level alone sets it.
- R5: With `rx_mode` = 2'b11, `rx_flag` is set on the clock after any cycle in which `rx_count` = DEPTH.
- R6: With `rx_mode` = 2'b10, `rx_flag` is set on the clock after any cycle in which `rx_count` ≥ DEPTH/2.
- R7: With `rx_mode` = 2'b01, `rx_flag` is set on the clock after any cycle in which `rx_count` ≠ 0.
- R8: With `rx_mode` = 2'b00, `rx_flag` is set on the clock after a cycle in which `rx_pop` is high and `rx_count` = 1, which means the last word is being read.
- R9: When `rx_push` is high while `rx_count` = DEPTH, `rx_wr_en` stays low in that cycle. On the next clock `err_why` bit 0 (overflow) and `err_flag` are set. Otherwise `rx_wr_en` equals `rx_push`.
- R10: When `tx_pop` is high while `tx_count` = 0, `tx_rd_en` stays low in that cycle. On the next clock `err_why` bit 1 (underrun) and `err_flag` are set. Otherwise `tx_rd_en` equals `tx_pop`.
- R11: A high `frame_err` sets `err_why` bit 2 and `err_flag` on the next clock. `err_flag` is high exactly when some `err_why` bit is high.
- R12: Once set, a flag or cause bit holds until its clear strobe is high in a cycle with no new event. The clear for `err_flag` and all `err_why` bits is `clr_err`. If a clear and an event fall in the same cycle, the flag stays set.
- R13: A synchronous active-high `rst` clears `tx_flag`, `rx_flag`, `err_flag` and `err_why` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 2 | Transmit event condition select |
| rx_mode | input | 2 | Receive event condition select |
| tx_count | input | $clog2(DEPTH)+1 | Words held in the transmit FIFO |
| rx_count | input | $clog2(DEPTH)+1 | Words held in the receive FIFO |
| tx_pop | input | 1 | Shifter requests the next transmit word |
| rx_push | input | 1 | A received word has been assembled |
| rx_pop | input | 1 | Software reads a word from the receive FIFO |
| shift_done | input | 1 | Shifter finished sending a word |
| frame_err | input | 1 | Frame error pulse |
| clr_tx | input | 1 | Write-one-to-clear for tx_flag |
| clr_rx | input | 1 | Write-one-to-clear for rx_flag |
| clr_err | input | 1 | Write-one-to-clear for err_flag and err_why |
| tx_rd_en | output | 1 | Gated read strobe to the transmit FIFO |
| rx_wr_en | output | 1 | Gated write strobe to the receive FIFO |
| tx_flag | output | 1 | Sticky transmit event flag |
| rx_flag | output | 1 | Sticky receive event flag |
| err_flag | output | 1 | Sticky combined error flag |
| err_why | output | 3 | Sticky error causes: bit 0 overflow, bit 1 underrun, bit 2 frame |

## Verification
The bench covers several kinds of internal fault, and each shows up at the ports within one clock of its cause. A wrong condition decode or a swapped mode shows up in the flags on the clock edge after the deciding cycle. A sticky bit that leaks or clears too readily differs from the bench model on the very next edge. A mis-gated FIFO strobe is visible combinationally in the same cycle as the offending request. Because of this, the bench compares every output every cycle across random modes, counts and strobes. It also steers directed cases to the boundary counts 0, 1, DEPTH/2 and DEPTH.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

    typedef enum logic [1:0] {
        TXS_DONE  = 2'b00,
        TXS_EMPTY = 2'b01,
        TXS_HALF  = 2'b10,
        TXS_ROOM  = 2'b11
    } tx_sel_e;

    typedef enum logic [1:0] {
        RXS_DRAINED = 2'b00,
        RXS_ANY     = 2'b01,
        RXS_HALF    = 2'b10,
        RXS_FULL    = 2'b11
    } rx_sel_e;

    typedef struct packed {
        logic frame;
        logic underrun;
        logic overflow;
    } err_why_t;

    localparam int unsigned WHY_W = $bits(err_why_t);

    function automatic logic reaches_half(input int unsigned amount, input int unsigned depth);
        return (amount << 1) >= depth;
    endfunction

    function automatic logic power_of_two(input int unsigned value);
        return (value != 0) && ((value & (value - 1)) == 0);
    endfunction

endpackage

// File: rtl/spi_tx_event.sv
module spi_tx_event
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  tx_sel_e         sel,
    input  logic [CW-1:0]   count,
    input  logic            shift_done,
    output logic            event_o
);
    logic [CW-1:0] free_slots;
    logic          has_room;
    logic          half_free;
    logic          drained;

    always_comb begin
        free_slots = CW'(DEPTH) - count;
        has_room   = count != CW'(DEPTH);
        half_free  = reaches_half(32'(free_slots), DEPTH);
        drained    = count == '0;
        unique case (sel)
            TXS_ROOM:  event_o = has_room;
            TXS_HALF:  event_o = half_free;
            TXS_EMPTY: event_o = drained;
            default:   event_o = drained && shift_done;
        endcase
    end
endmodule

// File: rtl/spi_rx_event.sv
module spi_rx_event
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  rx_sel_e         sel,
    input  logic [CW-1:0]   count,
    input  logic            rd_strobe,
    output logic            event_o
);
    logic is_full;
    logic half_full;
    logic non_empty;
    logic last_read;

    always_comb begin
        is_full   = count == CW'(DEPTH);
        half_full = reaches_half(32'(count), DEPTH);
        non_empty = count != '0;
        last_read = rd_strobe && (count == CW'(1));
        unique case (sel)
            RXS_FULL:  event_o = is_full;
            RXS_HALF:  event_o = half_full;
            RXS_ANY:   event_o = non_empty;
            default:   event_o = last_read;
        endcase
    end
endmodule

// File: rtl/spi_err_detect.sv
module spi_err_detect
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0]   tx_count,
    input  logic [CW-1:0]   rx_count,
    input  logic            tx_pop,
    input  logic            rx_push,
    input  logic            frame_err,
    output logic            tx_rd_en,
    output logic            rx_wr_en,
    output err_why_t        cause
);
    logic tx_dry;
    logic rx_brim;

    always_comb begin
        tx_dry         = tx_count == '0;
        rx_brim        = rx_count == CW'(DEPTH);
        cause.overflow = rx_push && rx_brim;
        cause.underrun = tx_pop && tx_dry;
        cause.frame    = frame_err;
        tx_rd_en       = tx_pop && !tx_dry;
        rx_wr_en       = rx_push && !rx_brim;
    end
endmodule

// File: rtl/spi_sticky.sv
module spi_sticky #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~{W{clr}}) | set;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((q & $past(q)) == $past(q))); // R12
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((q & $past(set)) == $past(set))); // R12
endmodule

// File: rtl/spi_irq_events.sv
module spi_irq_events
    import spi_evt_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      tx_mode,
    input  logic [1:0]      rx_mode,
    input  logic [CW-1:0]   tx_count,
    input  logic [CW-1:0]   rx_count,
    input  logic            tx_pop,
    input  logic            rx_push,
    input  logic            rx_pop,
    input  logic            shift_done,
    input  logic            frame_err,
    input  logic            clr_tx,
    input  logic            clr_rx,
    input  logic            clr_err,
    output logic            tx_rd_en,
    output logic            rx_wr_en,
    output logic            tx_flag,
    output logic            rx_flag,
    output logic            err_flag,
    output logic [2:0]      err_why
);
    localparam int unsigned NUM_DIR = 2;

    initial begin
        if (!power_of_two(DEPTH) || DEPTH < 2) begin
            $error("DEPTH must be a power of two, at least 2");
        end
    end

    logic           tx_ev;
    logic           rx_ev;
    err_why_t       cause_now;
    logic [WHY_W-1:0] why_q;
    logic [NUM_DIR-1:0] dir_set;
    logic [NUM_DIR-1:0] dir_clr;
    logic [NUM_DIR-1:0] dir_q;

    spi_tx_event #(.DEPTH(DEPTH)) u_tx_ev (
        .sel        (tx_sel_e'(tx_mode)),
        .count      (tx_count),
        .shift_done (shift_done),
        .event_o    (tx_ev)
    );

    spi_rx_event #(.DEPTH(DEPTH)) u_rx_ev (
        .sel       (rx_sel_e'(rx_mode)),
        .count     (rx_count),
        .rd_strobe (rx_pop),
        .event_o   (rx_ev)
    );

    spi_err_detect #(.DEPTH(DEPTH)) u_err (
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .frame_err (frame_err),
        .tx_rd_en  (tx_rd_en),
        .rx_wr_en  (rx_wr_en),
        .cause     (cause_now)
    );

    assign dir_set = {rx_ev, tx_ev};
    assign dir_clr = {clr_rx, clr_tx};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        spi_sticky #(.W(1)) u_flag (
            .clk (clk),
            .rst (rst),
            .set (dir_set[d]),
            .clr (dir_clr[d]),
            .q   (dir_q[d])
        );
    end

    spi_sticky #(.W(WHY_W)) u_why (
        .clk (clk),
        .rst (rst),
        .set (cause_now),
        .clr (clr_err),
        .q   (why_q)
    );

    assign tx_flag  = dir_q[0];
    assign rx_flag  = dir_q[1];
    assign err_why  = why_q;
    assign err_flag = |why_q;

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_count == CW'(DEPTH)) |-> !rx_wr_en); // R9
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_count == CW'(DEPTH)) |=> (err_flag && err_why[0])); // R9
    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && tx_count == '0) |=> (err_flag && err_why[1] && !$past(tx_rd_en))); // R10
    AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> err_why[2]); // R11
    AST_TX_EMPTY_MODE: assert property (@(posedge clk) disable iff (rst)
        (tx_mode == 2'b01 && tx_count == '0) |=> tx_flag); // R3
    AST_RX_FULL_MODE: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == 2'b11 && rx_count == CW'(DEPTH)) |=> rx_flag); // R5
    AST_TX_CLEARABLE: assert property (@(posedge clk) disable iff (rst)
        (clr_tx && tx_mode == 2'b00 && !shift_done) |=> !tx_flag); // R4
endmodule

// File: tb/spi_irq_events_test.sv
module spi_irq_events_test;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned CW     = $clog2(DEPTH) + 1;
    localparam time         PERIOD = 10ns;
    localparam int          NRAND  = 4000;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    tx_mode, rx_mode;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_pop, rx_push, rx_pop, shift_done, frame_err;
    logic          clr_tx, clr_rx, clr_err;
    logic          tx_rd_en, rx_wr_en, tx_flag, rx_flag, err_flag;
    logic [2:0]    err_why;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic       e_tx, e_rx;
    logic [2:0] e_why;

    always #(PERIOD/2) clk = ~clk;

    spi_irq_events #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .tx_count(tx_count), .rx_count(rx_count), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .shift_done(shift_done),
        .frame_err(frame_err), .clr_tx(clr_tx), .clr_rx(clr_rx),
        .clr_err(clr_err), .tx_rd_en(tx_rd_en), .rx_wr_en(rx_wr_en),
        .tx_flag(tx_flag), .rx_flag(rx_flag), .err_flag(err_flag),
        .err_why(err_why)
    );

    function automatic string tx_req(input logic [1:0] m);
        case (m)
            2'b11: return "R1";
            2'b10: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string rx_req(input logic [1:0] m);
        case (m)
            2'b11: return "R5";
            2'b10: return "R6";
            2'b01: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic tx_expect(input logic [1:0] m, input int cnt, input logic sd);
        case (m)
            2'b11: return cnt < DEPTH;
            2'b10: return 2 * (DEPTH - cnt) >= DEPTH;
            2'b01: return cnt == 0;
            default: return sd && cnt == 0;
        endcase
    endfunction

    function automatic logic rx_expect(input logic [1:0] m, input int cnt, input logic rd);
        case (m)
            2'b11: return cnt == DEPTH;
            2'b10: return 2 * cnt >= DEPTH;
            2'b01: return cnt != 0;
            default: return rd && cnt == 1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        tx_pop = 0; rx_push = 0; rx_pop = 0; shift_done = 0; frame_err = 0;
        clr_tx = 0; clr_rx = 0; clr_err = 0;
    endtask

    // inputs already driven just after a falling edge; check strobes,
    // advance one clock, compare registered flags at the next falling edge
    task automatic step();
        logic       ov, un;
        int         tc, rc;
        tc = int'(tx_count);
        rc = int'(rx_count);
        #1;
        ov = rx_push && rc == DEPTH;
        un = tx_pop && tc == 0;
        check("R9", rx_wr_en, rx_push && !ov);
        check("R10", tx_rd_en, tx_pop && !un);
        e_tx  = (e_tx & ~clr_tx) | tx_expect(tx_mode, tc, shift_done);
        e_rx  = (e_rx & ~clr_rx) | rx_expect(rx_mode, rc, rx_pop);
        e_why = (e_why & ~{3{clr_err}}) | {frame_err, un, ov};
        @(negedge clk);
        check(tx_req(tx_mode), tx_flag, e_tx);
        check(rx_req(rx_mode), rx_flag, e_rx);
        check("R12", err_why, e_why);
        check("R11", err_flag, |e_why);
    endtask

    function automatic logic [CW-1:0] pick_count();
        case ($urandom_range(5, 0))
            0: return '0;
            1: return CW'(1);
            2: return CW'(DEPTH / 2);
            3: return CW'(DEPTH);
            4: return CW'(DEPTH / 2 - 1);
            default: return CW'($urandom_range(DEPTH, 0));
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1; idle_inputs();
        tx_mode = 2'b00; rx_mode = 2'b00;
        tx_count = CW'(4); rx_count = CW'(4);
        e_tx = 0; e_rx = 0; e_why = 0;
        repeat (3) @(negedge clk);
        // R13: reset state, even with an event pending at the input
        frame_err = 1;
        @(negedge clk);
        check("R13", {tx_flag, rx_flag, err_flag, err_why}, 6'b0);
        rst = 0; frame_err = 0;
        @(negedge clk);
        check("R13", {tx_flag, rx_flag, err_flag, err_why}, 6'b0);

        // R4: mode 00 level alone does not set; shift_done with empty does
        tx_count = '0; step();
        check("R4", tx_flag, 1'b0);
        shift_done = 1; step(); shift_done = 0;
        check("R4", tx_flag, 1'b1);
        // R12: hold while no clear, then clear
        step();
        check("R12", tx_flag, 1'b1);
        clr_tx = 1; step(); clr_tx = 0;
        check("R12", tx_flag, 1'b0);
        // R12: clear and event together keep flag set
        tx_mode = 2'b01; clr_tx = 1; step(); clr_tx = 0;
        check("R3", tx_flag, 1'b1);
        // R2 boundary: free slots DEPTH/2 - 1 -> no event
        tx_mode = 2'b10; tx_count = CW'(DEPTH / 2 + 1); clr_tx = 1; step(); clr_tx = 0;
        check("R2", tx_flag, 1'b0);
        tx_count = CW'(DEPTH / 2); step();
        check("R2", tx_flag, 1'b1);
        // R1 boundary: full -> no event
        tx_mode = 2'b11; tx_count = CW'(DEPTH); clr_tx = 1; step(); clr_tx = 0;
        check("R1", tx_flag, 1'b0);
        // R8: read with two words -> none; read of last word -> set
        rx_mode = 2'b00; rx_count = CW'(2); rx_pop = 1; clr_rx = 1; step(); clr_rx = 0;
        check("R8", rx_flag, 1'b0);
        rx_count = CW'(1); step(); rx_pop = 0;
        check("R8", rx_flag, 1'b1);
        // R6 boundary
        rx_mode = 2'b10; rx_count = CW'(DEPTH / 2 - 1); clr_rx = 1; step(); clr_rx = 0;
        check("R6", rx_flag, 1'b0);
        // R7 and R5
        rx_mode = 2'b01; rx_count = '0; step();
        check("R7", rx_flag, 1'b0);
        rx_mode = 2'b11; rx_count = CW'(DEPTH - 1); step();
        check("R5", rx_flag, 1'b0);
        rx_count = CW'(DEPTH); step();
        check("R5", rx_flag, 1'b1);
        // R9: overflow drops the write, sets cause bit 0
        rx_push = 1; step(); rx_push = 0;
        check("R9", err_why, 3'b001);
        // R10: underrun, R11: frame, all accumulate
        tx_count = '0; tx_pop = 1; step(); tx_pop = 0;
        check("R10", err_why, 3'b011);
        frame_err = 1; step(); frame_err = 0;
        check("R11", {err_flag, err_why}, 4'b1111);
        clr_err = 1; step(); clr_err = 0;
        check("R12", {err_flag, err_why}, 4'b0000);

        // constrained random phase
        for (int i = 0; i < NRAND; i++) begin
            tx_mode    = 2'($urandom_range(3, 0));
            rx_mode    = 2'($urandom_range(3, 0));
            tx_count   = pick_count();
            rx_count   = pick_count();
            tx_pop     = ($urandom_range(3, 0) == 0);
            rx_push    = ($urandom_range(3, 0) == 0);
            rx_pop     = ($urandom_range(3, 0) == 0);
            shift_done = ($urandom_range(3, 0) == 0);
            frame_err  = ($urandom_range(15, 0) == 0);
            clr_tx     = ($urandom_range(1, 0) == 0);
            clr_rx     = ($urandom_range(1, 0) == 0);
            clr_err    = ($urandom_range(2, 0) == 0);
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule